// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block decides, once per clock, whether the processor leaves normal execution for a privileged handler. Four interrupt request lines compete, and a three-bit priority level gates them. Each level masks a growing set of the lower sources. Synchronous exceptions arrive as a request strobe with an entry index.

When an entry is taken, the block computes the handler address from a base register and an entry offset. It saves the interrupted PC with the current mode folded into bit 0, forces the privileged flag on, and emits a one-cycle pulse carrying the cause. Two things keep interrupts out: the privileged flag, and a pending exception.

All interfaces are plain control and status pins. Requests are level or strobe signals that the block samples every cycle. There is no valid/ready handshake and no back-pressure, because an accepted exception is always consumed on the following edge. Interrupt lines are not latched. The source that raised a line must drop it after seeing the pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: No interrupt is taken in a cycle where `priv_i` is high, or where `priv_o` is high (the cycle right after any entry).
- R2: Among the unmasked pending lines, the highest priority one is taken. Priority rises in this order: device, clock, interprocessor, machine check. `cause_o` reports the source as device=0, clock=1, interprocessor=2, machine check=3, with `taken_irq_o`=1.
- R3: Each source is accepted only at low enough levels. Device needs `ipl_i` <= 3, clock needs <= 4, interprocessor needs <= 5 and machine check needs <= 6. Level 7 accepts nothing.
- R4: On every entry, `exc_addr_o` equals the `pc_i` of the taking cycle ORed with `priv_i` of that cycle in bit 0.
- R5: On every entry, `pc_o` = `base_i` + entry offset and `priv_o` = 1.
- R6: The interrupt entry offsets are 0x080 for machine check and 0x100 for clock. Device and interprocessor share 0x180.
- R7: For an exception with index >= 0x80, the offset is 0x2000 + (index - 0x80) * 64. For an index below 0x80, the offset is (index mod 64) * 128.
- R8: When `exc_req_i` is high at an edge, the exception is taken at the next edge, with `taken_irq_o`=0 and `cause_o` = the index. No interrupt is taken at either of those two edges. The privileged flag does not block exceptions.
- R9: The pending exception clears once taken. Each strobe yields exactly one entry, and strobes on back-to-back cycles are taken on back-to-back cycles in order.
- R10: `taken_o` is high for exactly one cycle per entry. Without an entry, `pc_o`, `exc_addr_o` and `cause_o` hold, and `priv_o` follows `priv_i` one cycle late. After reset, `taken_o`=0, `pc_o`=0, `exc_addr_o`=0 and `priv_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_dev_i | input | 1 | Device interrupt line |
| irq_clk_i | input | 1 | Clock/timer interrupt line |
| irq_ipi_i | input | 1 | Interprocessor interrupt line |
| irq_mchk_i | input | 1 | Machine check line |
| ipl_i | input | LVL_W | Current interrupt priority level |
| priv_i | input | 1 | Processor is in privileged mode |
| pc_i | input | ADDR_W | Current program counter |
| base_i | input | ADDR_W | Privileged handler base address |
| exc_req_i | input | 1 | Synchronous exception strobe |
| exc_idx_i | input | IDX_W | Exception entry index |
| pc_o | output | ADDR_W | Handler address after entry |
| exc_addr_o | output | ADDR_W | Saved return address with mode in bit 0 |
| priv_o | output | 1 | Privileged flag after entry |
| taken_o | output | 1 | One-cycle entry pulse |
| taken_irq_o | output | 1 | Entry was an interrupt |
| cause_o | output | IDX_W | Source code or exception index |

## Verification
The interrupt sweep applies every combination of the four request lines at every priority level, with the privileged flag both low and high. That separates masking thresholds that are off by one level, priority inversions between adjacent sources, and gating by the mode flag.

The exception sweep walks all 256 indices while every interrupt line is raised. That shows the split between the call region and the plain region, the exact slot arithmetic, and that exceptions win over interrupts.

Back-to-back strobes and a held interrupt line show that pending state clears and that the pulse does not repeat.

// File: rtl/irq_entry_seq_pkg.sv
`timescale 1ns/1ps
package irq_entry_seq_pkg;
  localparam int NUM_SRC = 4;
  // source numbering equals priority rank (higher value wins)
  typedef enum logic [1:0] {
    SRC_DEV  = 2'd0,
    SRC_CLK  = 2'd1,
    SRC_IPI  = 2'd2,
    SRC_MCHK = 2'd3
  } irq_src_e;

  // the device line is accepted at levels up to this value; each higher source one more
  localparam int FIRST_LEVEL_LIMIT = 3;

  localparam int OFF_MCHK = 'h080;
  localparam int OFF_CLK  = 'h100;
  localparam int OFF_IO   = 'h180;

  localparam int CALL_REGION = 'h2000;
  localparam int CALL_SLOT_SHIFT = 6;   // 64-byte call slots
  localparam int PLAIN_SLOT_SHIFT = 7;  // 128-byte plain slots
  localparam int PLAIN_IDX_BITS = 6;

  function automatic int irq_offset(irq_src_e s);
    case (s)
      SRC_MCHK: return OFF_MCHK;
      SRC_CLK:  return OFF_CLK;
      default:  return OFF_IO;
    endcase
  endfunction
endpackage

// File: rtl/irq_seq_arbiter.sv
`timescale 1ns/1ps
module irq_seq_arbiter
  import irq_entry_seq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [LVL_W-1:0]   ipl,
  input  logic               block,
  output logic               sel_vld,
  output irq_src_e           sel_src
);
  logic [NUM_SRC-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_mask
      localparam int LIMIT = FIRST_LEVEL_LIMIT + g;
      assign elig[g] = req[g] && !block && (int'(ipl) <= LIMIT);
    end
  endgenerate

  always_comb begin
    sel_vld = 1'b0;
    sel_src = SRC_DEV;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i]) begin
        sel_vld = 1'b1;
        sel_src = irq_src_e'(i);
      end
    end
  end
endmodule

// File: rtl/irq_seq_vector.sv
`timescale 1ns/1ps
module irq_seq_vector
  import irq_entry_seq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 8
) (
  input  logic              is_irq,
  input  irq_src_e          src,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [IDX_W-1:0] CALL_START = IDX_W'(1) << (IDX_W - 1);
  localparam logic [ADDR_W-1:0] CALL_BASE = ADDR_W'(CALL_REGION);

  logic [IDX_W-1:0]  call_rel;
  logic [ADDR_W-1:0] call_off;
  logic [ADDR_W-1:0] plain_off;

  assign call_rel  = idx - CALL_START;
  assign call_off  = CALL_BASE + (ADDR_W'(call_rel) << CALL_SLOT_SHIFT);
  assign plain_off = ADDR_W'(idx[PLAIN_IDX_BITS-1:0]) << PLAIN_SLOT_SHIFT;

  always_comb begin
    if (is_irq)                offset = ADDR_W'(irq_offset(src));
    else if (idx >= CALL_START) offset = call_off;
    else                       offset = plain_off;
  end
endmodule

// File: rtl/irq_seq_excq.sv
`timescale 1ns/1ps
module irq_seq_excq #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  output logic             pend_vld,
  output logic [IDX_W-1:0] pend_idx
);
  // a pending entry is always consumed on the following edge, so the next
  // state is simply whatever arrives now; no arrival returns the slot to none
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_idx <= '0;
    end else begin
      pend_vld <= load;
      if (load) pend_idx <= load_idx;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
  import irq_entry_seq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_dev_i,
  input  logic              irq_clk_i,
  input  logic              irq_ipi_i,
  input  logic              irq_mchk_i,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              exc_req_i,
  input  logic [IDX_W-1:0]  exc_idx_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] exc_addr_o,
  output logic              priv_o,
  output logic              taken_o,
  output logic              taken_irq_o,
  output logic [IDX_W-1:0]  cause_o
);
  logic              pend_vld;
  logic [IDX_W-1:0]  pend_idx;
  logic              irq_block;
  logic              irq_vld;
  irq_src_e          irq_src;
  logic [ADDR_W-1:0] entry_off;
  logic              take_exc;
  logic              take_any;
  logic [NUM_SRC-1:0] req_vec;

  assign req_vec = {irq_mchk_i, irq_ipi_i, irq_clk_i, irq_dev_i};
  // interrupts wait out privileged mode, the cycle after an entry and any exception in flight
  assign irq_block = priv_i | priv_o | pend_vld | exc_req_i;

  irq_seq_excq #(.IDX_W(IDX_W)) u_excq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (exc_req_i),
    .load_idx (exc_idx_i),
    .pend_vld (pend_vld),
    .pend_idx (pend_idx)
  );

  irq_seq_arbiter #(.LVL_W(LVL_W)) u_arb (
    .req     (req_vec),
    .ipl     (ipl_i),
    .block   (irq_block),
    .sel_vld (irq_vld),
    .sel_src (irq_src)
  );

  assign take_exc = pend_vld;
  assign take_any = take_exc | irq_vld;

  irq_seq_vector #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_vec (
    .is_irq (!take_exc),
    .src    (irq_src),
    .idx    (pend_idx),
    .offset (entry_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o        <= '0;
      exc_addr_o  <= '0;
      priv_o      <= 1'b1;
      taken_o     <= 1'b0;
      taken_irq_o <= 1'b0;
      cause_o     <= '0;
    end else if (take_any) begin
      pc_o        <= base_i + entry_off;
      exc_addr_o  <= pc_i | ADDR_W'(priv_i);
      priv_o      <= 1'b1;
      taken_o     <= 1'b1;
      taken_irq_o <= !take_exc;
      cause_o     <= take_exc ? pend_idx : IDX_W'(irq_src);
    end else begin
      priv_o      <= priv_i;
      taken_o     <= 1'b0;
      taken_irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
`timescale 1ns/1ps
module irq_entry_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_dev_i,
  input logic              irq_clk_i,
  input logic              irq_ipi_i,
  input logic              irq_mchk_i,
  input logic [LVL_W-1:0]  ipl_i,
  input logic              priv_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              exc_req_i,
  input logic [IDX_W-1:0]  exc_idx_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] exc_addr_o,
  input logic              priv_o,
  input logic              taken_o,
  input logic              taken_irq_o,
  input logic [IDX_W-1:0]  cause_o
);
  assert_no_irq_in_priv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && taken_irq_o) |-> !$past(priv_i));

  assert_mchk_beats_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_irq_o && $past(irq_mchk_i) && int'($past(ipl_i)) <= 6) |-> (cause_o == IDX_W'(3)));

  assert_dev_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_irq_o && cause_o == '0) |-> (int'($past(ipl_i)) <= 3));

  assert_save_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (exc_addr_o == ($past(pc_i) | ADDR_W'($past(priv_i)))));

  assert_priv_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> priv_o);

  assert_exc_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exc_req_i, 2) |-> (taken_o && !taken_irq_o && cause_o == $past(exc_idx_i, 2)));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && taken_irq_o) |=> !(taken_o && taken_irq_o));

  assert_hold_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |=> (!taken_o -> $stable(pc_o)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_dev_i = 0, irq_clk_i = 0, irq_ipi_i = 0, irq_mchk_i = 0;
  logic [2:0]  ipl_i = '0;
  logic        priv_i = 1'b0;
  logic [63:0] pc_i = '0, base_i = '0;
  logic        exc_req_i = 1'b0;
  logic [7:0]  exc_idx_i = '0;
  logic [63:0] pc_o, exc_addr_o;
  logic        priv_o, taken_o, taken_irq_o;
  logic [7:0]  cause_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .irq_dev_i(irq_dev_i), .irq_clk_i(irq_clk_i), .irq_ipi_i(irq_ipi_i), .irq_mchk_i(irq_mchk_i),
    .ipl_i(ipl_i), .priv_i(priv_i), .pc_i(pc_i), .base_i(base_i),
    .exc_req_i(exc_req_i), .exc_idx_i(exc_idx_i),
    .pc_o(pc_o), .exc_addr_o(exc_addr_o), .priv_o(priv_o),
    .taken_o(taken_o), .taken_irq_o(taken_irq_o), .cause_o(cause_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exc_off(input int idx);
    if (idx >= 128) return 64'(32'h2000 + (idx - 128) * 64);
    return 64'((idx % 64) * 128);
  endfunction

  task automatic idle();
    irq_dev_i = 0; irq_clk_i = 0; irq_ipi_i = 0; irq_mchk_i = 0;
    priv_i = 0; exc_req_i = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] last_pc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset taken", 64'(taken_o), 64'd0);
    chk("R10 reset pc", pc_o, 64'd0);
    chk("R10 reset exc_addr", exc_addr_o, 64'd0);
    chk("R10 reset priv", 64'(priv_o), 64'd1);
    rst_n = 1'b1;
    idle();
    @(negedge clk);

    // interrupt sweep: R1 R2 R3 R4 R5 R6
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int rq = 0; rq < 16; rq++) begin
        for (int pm = 0; pm < 2; pm++) begin
          int sel;
          logic [63:0] off;
          logic [63:0] pcv, bv;
          pcv = 64'h4000_0000 + 64'(lvl * 256 + rq * 8 + pm * 4 + (rq & 1));
          bv  = 64'h0001_0000_0000 + 64'(lvl) * 64'h10000;
          sel = -1;
          for (int s = 0; s < 4; s++)
            if (rq[s] && lvl <= 3 + s && pm == 0) sel = s;
          last_pc = pc_o;
          irq_dev_i = rq[0]; irq_clk_i = rq[1]; irq_ipi_i = rq[2]; irq_mchk_i = rq[3];
          ipl_i = 3'(lvl); priv_i = pm[0]; pc_i = pcv; base_i = bv;
          @(negedge clk);
          chk("R1/R3 taken", 64'(taken_o), 64'(sel >= 0));
          if (sel >= 0) begin
            off = (sel == 3) ? 64'h80 : (sel == 1) ? 64'h100 : 64'h180;
            chk("R2 cause", 64'(cause_o), 64'(sel));
            chk("R2 irq flag", 64'(taken_irq_o), 64'd1);
            chk("R5/R6 new pc", pc_o, bv + off);
            chk("R4 saved addr", exc_addr_o, pcv | 64'(pm));
            chk("R5 priv set", 64'(priv_o), 64'd1);
          end else begin
            chk("R10 pc hold", pc_o, last_pc);
            chk("R10 priv follow", 64'(priv_o), 64'(pm));
          end
          idle();
          @(negedge clk);
        end
      end
    end

    // exception sweep with all interrupts raised: R7 R8
    for (int ix = 0; ix < 256; ix++) begin
      logic [63:0] pcv, bv;
      int pm;
      pm = ix & 1;
      pcv = 64'h8000_0000 + 64'(ix * 16 + ((ix >> 1) & 1));
      bv  = 64'h0020_0000 + 64'(ix) * 64'h100000;
      irq_dev_i = 1; irq_clk_i = 1; irq_ipi_i = 1; irq_mchk_i = 1;
      ipl_i = '0; priv_i = pm[0]; pc_i = pcv; base_i = bv;
      exc_req_i = 1; exc_idx_i = 8'(ix);
      @(negedge clk);
      exc_req_i = 0;
      chk("R8 no take on strobe edge", 64'(taken_o), 64'd0);
      @(negedge clk);
      chk("R8 exception taken", 64'(taken_o), 64'd1);
      chk("R8 not irq", 64'(taken_irq_o), 64'd0);
      chk("R8 cause index", 64'(cause_o), 64'(ix));
      chk("R7 exception pc", pc_o, bv + exc_off(ix));
      chk("R4 exc saved addr", exc_addr_o, pcv | 64'(pm));
      idle();
      @(negedge clk);
      @(negedge clk);
    end

    // back-to-back strobes: R9
    base_i = 64'h1000_0000; pc_i = 64'h2222_0000; priv_i = 1;
    exc_req_i = 1; exc_idx_i = 8'h85;
    @(negedge clk);
    exc_idx_i = 8'h03;
    chk("R9 none yet", 64'(taken_o), 64'd0);
    @(negedge clk);
    exc_req_i = 0;
    chk("R9 first taken", 64'(taken_o), 64'd1);
    chk("R9 first cause", 64'(cause_o), 64'h85);
    chk("R9 first pc", pc_o, 64'h1000_0000 + 64'h2000 + 64'd5 * 64);
    @(negedge clk);
    chk("R9 second taken", 64'(taken_o), 64'd1);
    chk("R9 second cause", 64'(cause_o), 64'h03);
    chk("R9 second pc", pc_o, 64'h1000_0000 + 64'd3 * 128);
    @(negedge clk);
    chk("R9 pending cleared", 64'(taken_o), 64'd0);
    idle();
    @(negedge clk);

    // held device line: R10 pulse then lockout for one cycle
    irq_dev_i = 1; ipl_i = '0; priv_i = 0;
    @(negedge clk);
    chk("R10 first pulse", 64'(taken_o), 64'd1);
    @(negedge clk);
    chk("R10 pulse ends", 64'(taken_o), 64'd0);
    @(negedge clk);
    chk("R10 retake when line held", 64'(taken_o), 64'd1);
    idle();
    @(negedge clk);
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule